// File: doc/BRIEF.md
# Video Timing Word Detector and Clipper

This block sits at the front of a serial video encoder. It takes one parallel video word per word clock, either a full 10-bit word or an 8-bit word that it widens to 10 bits. It watches the stream for the four-word timing sequences that mark where active video starts and ends. In standard-video mode it forces the near-extreme reserved codes to the exact extremes before the word goes on to the encoder and the error-check generators. It also latches the line, field and blanking flags from each timing status word, raises a new-sync-position level when the timing of a line changes, issues a one-cycle flush so that downstream scrambler, serializer and NRZI state restarts, and marks each ancillary data header with a single-cycle pulse.

Every input is registered once. Each word therefore leaves on `word_out` two clock edges after it is presented, and every flag and strobe that belongs to that word appears in the same cycle. A sequencer follows the prefix of each sequence and has six states. ST_IDLE means no prefix is pending. ST_HI means the last word was high-extreme. ST_HI_LO means high then low were seen. ST_PRE means high, low, low were seen, so the next word is a status word. ST_LO means the last word was low-extreme. ST_LO_HI means low then high were seen. A high word in ST_LO_HI is an ancillary header. The word that follows ST_PRE is consumed as status, and the sequencer then restarts from that word's class. Any word that is neither extreme returns the sequencer to ST_IDLE. The sequencer is also held in ST_IDLE whenever detection is off. A position tracker counts words since the last end-of-active-video status and stores the last count seen at each kind of timing word.

In general-purpose mode the block acts as a plain widening register. No word is clipped, nothing is detected, and all flag, level and strobe outputs stay low.

Top module: `vsd_sync_clip`

## Requirements
- R1: With `narrow_sel` high, the 8-bit value on `word_in[7:0]` is placed in bits 9:2 of the internal word, and bits 1:0 are zero.
- R2: In standard mode (`raw_mode` low), a word of value 0x000 to 0x003 leaves as 0x000, a word of value 0x3FC to 0x3FF leaves as 0x3FF, and every other word leaves unchanged.
- R3: Timing sequences and ancillary headers are recognised only while `det_en_n` is low. While it is high, the flags hold their values and no pulse, flush or new-sync-position change occurs.
- R4: After reset all outputs are low. Each word, and every output caused by it, appears two clock edges after the word is presented.
- R5: A timing sequence is a high-extreme word, two low-extreme words and a status word. On the status word, `flag_f`, `flag_v` and `flag_h` load its bits 8, 7 and 6, and they hold until the next status word. Bit 6 high means end of active video.
- R6: `nsp` goes high on a timing status word of either kind in two cases: when no earlier word of that kind has been seen since reset or since the last general-purpose period, or when the count of words since the last end-of-active-video status differs from the count stored for that kind. The stored count is then replaced.
- R7: `nsp` stays high until an end-of-active-video status arrives at its expected count, which clears it. A new mismatch sets it again.
- R8: `flush` is high for exactly one cycle with each event that sets `nsp` under R6.
- R9: `anc_pulse` is high for one cycle when a low-extreme word is followed by two high-extreme words.
- R10: In general-purpose mode (`raw_mode` high), words pass unclipped, flags, `nsp`, `flush` and `anc_pulse` are low, and stored counts are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_in | input | 10 | Parallel video word |
| narrow_sel | input | 1 | High: 8-bit word on bits 7:0 |
| det_en_n | input | 1 | Low enables sequence detection |
| raw_mode | input | 1 | High selects general-purpose mode |
| word_out | output | 10 | Widened, clipped word |
| flag_h | output | 1 | Horizontal (end-of-active) flag |
| flag_v | output | 1 | Vertical blanking flag |
| flag_f | output | 1 | Field flag |
| nsp | output | 1 | New or misplaced sync position level |
| anc_pulse | output | 1 | Ancillary header pulse |
| flush | output | 1 | One-cycle downstream restart strobe |

## Verification
The single-pulse and flush properties assume that two timing sequences or two ancillary headers never overlap closer than their own length. This holds for any stream that keeps the reserved extreme codes for timing use. The bench respects this: it draws ordinary video words only from the non-reserved range, and its status words always have bit 9 set with parity in bits 5:2, so a status word is never mistaken for an extreme code. Reserved near-extreme values appear only inside prefixes and headers, except in general-purpose stretches, where the assertions expect no detection at all.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI,
        ST_HI_LO,
        ST_PRE,
        ST_LO,
        ST_LO_HI
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_MID,
        CLS_LO,
        CLS_HI
    } word_cls_e;
endpackage

// File: rtl/vsd_in_stage.sv
module vsd_in_stage #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              narrow_sel,
    input  logic              det_en_n,
    input  logic              raw_mode,
    output logic [WORD_W-1:0] word_q,
    output logic              detn_q,
    output logic              raw_q
);
    localparam int PAD_W = 2;
    localparam int NAR_W = WORD_W - PAD_W;

    logic [WORD_W-1:0] widened;

    always_comb begin
        if (narrow_sel) widened = {word_in[NAR_W-1:0], {PAD_W{1'b0}}};
        else            widened = word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            detn_q <= 1'b1;
            raw_q  <= 1'b0;
        end else begin
            word_q <= widened;
            detn_q <= det_en_n;
            raw_q  <= raw_mode;
        end
    end
endmodule

// File: rtl/vsd_seq_fsm.sv
module vsd_seq_fsm
    import vsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  word_cls_e cls,
    output logic      sync_hit,
    output logic      anc_hit
);
    seq_state_e cur, nxt;

    function automatic seq_state_e start_of(input word_cls_e c);
        if (c == CLS_HI)      return ST_HI;
        else if (c == CLS_LO) return ST_LO;
        else                  return ST_IDLE;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = ST_IDLE;
        if (active) begin
            unique case (cur)
                ST_IDLE, ST_PRE: nxt = start_of(cls);
                ST_HI:    nxt = (cls == CLS_LO) ? ST_HI_LO :
                                (cls == CLS_HI) ? ST_HI : ST_IDLE;
                ST_HI_LO: nxt = (cls == CLS_LO) ? ST_PRE :
                                (cls == CLS_HI) ? ST_LO_HI : ST_IDLE;
                ST_LO:    nxt = (cls == CLS_HI) ? ST_LO_HI :
                                (cls == CLS_LO) ? ST_LO : ST_IDLE;
                ST_LO_HI: nxt = (cls == CLS_HI) ? ST_HI :
                                (cls == CLS_LO) ? ST_HI_LO : ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sync_hit = active && (cur == ST_PRE);
        anc_hit  = active && (cur == ST_LO_HI) && (cls == CLS_HI);
    end
endmodule

// File: rtl/vsd_pos_track.sv
module vsd_pos_track #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic sync_hit,
    input  logic is_eav,
    output logic nsp,
    output logic flush
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt, eav_len, sav_len;
    logic             eav_ok, sav_ok;
    logic             eav_evt, sav_evt, off_pos;

    always_comb begin
        eav_evt = sync_hit && is_eav;
        sav_evt = sync_hit && !is_eav;
        off_pos = 1'b0;
        if (eav_evt)      off_pos = !eav_ok || (cnt != eav_len);
        else if (sav_evt) off_pos = !sav_ok || (cnt != sav_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; eav_len <= '0; sav_len <= '0;
            eav_ok <= 1'b0; sav_ok <= 1'b0;
            nsp <= 1'b0; flush <= 1'b0;
        end else if (raw) begin
            cnt <= '0; eav_ok <= 1'b0; sav_ok <= 1'b0;
            nsp <= 1'b0; flush <= 1'b0;
        end else begin
            if (eav_evt)              cnt <= '0;
            else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;
            if (eav_evt) begin
                eav_len <= cnt;
                eav_ok  <= 1'b1;
            end
            if (sav_evt) begin
                sav_len <= cnt;
                sav_ok  <= 1'b1;
            end
            flush <= off_pos;
            if (off_pos)      nsp <= 1'b1;
            else if (eav_evt) nsp <= 1'b0;
        end
    end
endmodule

// File: rtl/vsd_sync_clip.sv
module vsd_sync_clip
    import vsd_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              narrow_sel,
    input  logic              det_en_n,
    input  logic              raw_mode,
    output logic [WORD_W-1:0] word_out,
    output logic              flag_h,
    output logic              flag_v,
    output logic              flag_f,
    output logic              nsp,
    output logic              anc_pulse,
    output logic              flush
);
    localparam logic [WORD_W-1:0] TOP_V  = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] LO_LIM = WORD_W'(3);
    localparam logic [WORD_W-1:0] HI_LIM = TOP_V - WORD_W'(3);
    localparam int H_POS = WORD_W - 4;
    localparam int V_POS = WORD_W - 3;
    localparam int F_POS = WORD_W - 2;

    logic [WORD_W-1:0] word_q, clipped;
    logic              detn_q, raw_q, active, sync_hit, anc_hit;
    word_cls_e         cls;

    vsd_in_stage #(.WORD_W(WORD_W)) u_in (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .narrow_sel(narrow_sel),
        .det_en_n(det_en_n), .raw_mode(raw_mode),
        .word_q(word_q), .detn_q(detn_q), .raw_q(raw_q)
    );

    always_comb begin
        active = !raw_q && !detn_q;
        if (word_q <= LO_LIM)      cls = CLS_LO;
        else if (word_q >= HI_LIM) cls = CLS_HI;
        else                       cls = CLS_MID;
        unique case (cls)
            CLS_LO:  clipped = '0;
            CLS_HI:  clipped = TOP_V;
            default: clipped = word_q;
        endcase
    end

    vsd_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .active(active), .cls(cls),
        .sync_hit(sync_hit), .anc_hit(anc_hit)
    );

    vsd_pos_track #(.CNT_W(CNT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .raw(raw_q), .sync_hit(sync_hit),
        .is_eav(word_q[H_POS]), .nsp(nsp), .flush(flush)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out  <= '0;
            flag_h    <= 1'b0;
            flag_v    <= 1'b0;
            flag_f    <= 1'b0;
            anc_pulse <= 1'b0;
        end else begin
            word_out  <= raw_q ? word_q : clipped;
            anc_pulse <= anc_hit;
            if (raw_q) begin
                flag_h <= 1'b0;
                flag_v <= 1'b0;
                flag_f <= 1'b0;
            end else if (sync_hit) begin
                flag_h <= word_q[H_POS];
                flag_v <= word_q[V_POS];
                flag_f <= word_q[F_POS];
            end
        end
    end
endmodule

// File: rtl/vsd_sync_clip_chk.sv
module vsd_sync_clip_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raw_q,
    input logic [WORD_W-1:0] word_out,
    input logic              flag_h,
    input logic              flag_v,
    input logic              flag_f,
    input logic              nsp,
    input logic              anc_pulse,
    input logic              flush
);
    localparam logic [WORD_W-1:0] TOP_V = {WORD_W{1'b1}};

    assert_anc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        anc_pulse |=> !anc_pulse);

    assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_flush_with_nsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> nsp);

    assert_nsp_rise_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nsp) |-> flush);

    assert_nsp_clear_by_eav_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nsp) |-> (flag_h || $past(raw_q)));

    assert_raw_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q |=> (!nsp && !flush && !anc_pulse && !flag_h && !flag_v && !flag_f));

    assert_clip_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_q |=> ((word_out == '0 || word_out > WORD_W'(3)) &&
                    (word_out == TOP_V || word_out < TOP_V - WORD_W'(3))));
endmodule

bind vsd_sync_clip vsd_sync_clip_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .raw_q(raw_q), .word_out(word_out),
    .flag_h(flag_h), .flag_v(flag_v), .flag_f(flag_f), .nsp(nsp),
    .anc_pulse(anc_pulse), .flush(flush)
);

// File: tb/tb_vsd_sync_clip.sv
`timescale 1ns/1ps
module tb_vsd_sync_clip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       narrow_sel = 1'b0, det_en_n = 1'b0, raw_mode = 1'b0;
    logic [9:0] word_out;
    logic       flag_h, flag_v, flag_f, nsp, anc_pulse, flush;

    always #2 clk = ~clk;

    vsd_sync_clip dut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .narrow_sel(narrow_sel),
        .det_en_n(det_en_n), .raw_mode(raw_mode), .word_out(word_out),
        .flag_h(flag_h), .flag_v(flag_v), .flag_f(flag_f), .nsp(nsp),
        .anc_pulse(anc_pulse), .flush(flush)
    );

    int checks = 0, fails = 0;

    // model state
    int m_cnt = 0, m_eav_len = 0, m_sav_len = 0;
    bit m_eav_ok = 0, m_sav_ok = 0, m_nsp = 0;
    bit [2:0] m_flg = 0;
    int h1 = 0, h2 = 0, h3 = 0;   // 0 mid, 1 low, 2 high

    // two-deep expectation pipeline
    bit       pv[2];
    bit [9:0] pw[2];
    bit [2:0] pf[2];
    bit       pn[2], pa[2], pl[2], praw[2], pnar[2], pact[2];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cls_of(input bit [9:0] w);
        if (w <= 10'd3) return 1;
        if (w >= 10'h3FC) return 2;
        return 0;
    endfunction

    task automatic step(input bit [9:0] w, input bit nar, input bit dn, input bit rw);
        bit [9:0] padw, ew;
        int c;
        bit act, anc, sync, off;
        @(negedge clk);
        if (pv[1]) begin
            chk(praw[1] ? "R10 word" : (pnar[1] ? "R1 word" : "R2 word"), word_out, pw[1]);
            chk(pact[1] ? "R5 flags" : "R3 flags", {flag_f, flag_v, flag_h}, pf[1]);
            chk("R6,R7 nsp", nsp, pn[1]);
            chk(pact[1] ? "R9 anc" : "R3 anc", anc_pulse, pa[1]);
            chk("R8 flush", flush, pl[1]);
        end
        pv[1] = pv[0]; pw[1] = pw[0]; pf[1] = pf[0]; pn[1] = pn[0];
        pa[1] = pa[0]; pl[1] = pl[0]; praw[1] = praw[0]; pnar[1] = pnar[0];
        pact[1] = pact[0];
        word_in = w; narrow_sel = nar; det_en_n = dn; raw_mode = rw;
        padw = nar ? {w[7:0], 2'b00} : w;
        c = cls_of(padw);
        act = !rw && !dn;
        ew = rw ? padw : (c == 1 ? 10'h000 : (c == 2 ? 10'h3FF : padw));
        anc = act && h2 == 1 && h1 == 2 && c == 2;
        sync = act && h3 == 2 && h2 == 1 && h1 == 1;
        off = 0;
        if (rw) begin
            m_cnt = 0; m_eav_ok = 0; m_sav_ok = 0; m_flg = 0; m_nsp = 0;
        end else if (sync) begin
            m_flg = padw[8:6];
            if (padw[6]) begin
                off = !m_eav_ok || m_cnt != m_eav_len;
                m_eav_len = m_cnt; m_eav_ok = 1; m_cnt = 0;
                m_nsp = off;
            end else begin
                off = !m_sav_ok || m_cnt != m_sav_len;
                m_sav_len = m_cnt; m_sav_ok = 1;
                if (off) m_nsp = 1;
                if (m_cnt < 4095) m_cnt++;
            end
        end else if (m_cnt < 4095) m_cnt++;
        if (act) begin h3 = h2; h2 = h1; h1 = c; end
        else begin h3 = 0; h2 = 0; h1 = 0; end
        pv[0] = 1; pw[0] = ew; pf[0] = m_flg; pn[0] = m_nsp; pa[0] = anc;
        pl[0] = off; praw[0] = rw; pnar[0] = nar; pact[0] = act;
    endtask

    function automatic bit [9:0] rand_word(input bit nar);
        if (nar) return 10'($urandom_range(1, 254));
        return 10'($urandom_range(4, 10'h3FB));
    endfunction

    task automatic data(input int n, input bit nar, input bit dn, input bit rw);
        for (int i = 0; i < n; i++) step(rand_word(nar), nar, dn, rw);
    endtask

    // timing sequence; near selects the near-extreme prefix variant
    task automatic trs(input bit h, input bit v, input bit f, input bit near,
                       input bit nar, input bit dn, input bit rw);
        bit [9:0] st;
        st = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
        if (nar) begin
            step(10'h0FF, nar, dn, rw); step(10'h000, nar, dn, rw);
            step(10'h000, nar, dn, rw); step({2'b00, st[9:2]}, nar, dn, rw);
        end else begin
            step(near ? 10'h3FD : 10'h3FF, nar, dn, rw);
            step(near ? 10'h002 : 10'h000, nar, dn, rw);
            step(near ? 10'h001 : 10'h000, nar, dn, rw);
            step(st, nar, dn, rw);
        end
    endtask

    task automatic line(input int len, input int sav_at, input bit anc, input bit near,
                        input bit nar, input bit dn, input bit rw, input bit v);
        int used;
        trs(1'b1, v, 1'b0, near, nar, dn, rw);
        data(sav_at - 4, nar, dn, rw);
        trs(1'b0, v, 1'b0, near, nar, dn, rw);
        used = sav_at + 4;
        if (anc) begin
            step(nar ? 10'h000 : (near ? 10'h003 : 10'h000), nar, dn, rw);
            step(nar ? 10'h0FF : (near ? 10'h3FE : 10'h3FF), nar, dn, rw);
            step(nar ? 10'h0FF : 10'h3FF, nar, dn, rw);
            used += 3;
        end
        data(len - used, nar, dn, rw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4 reset word", word_out, 0);
        chk("R4 reset flags", {flag_f, flag_v, flag_h, nsp, anc_pulse, flush}, 0);
        rst_n = 1'b1;
        // regular lines: nsp set, then cleared by matching EAV (R6, R7)
        for (int i = 0; i < 4; i++) line(48, 12, 0, 0, 0, 0, 0, 0);
        line(48, 12, 1, 0, 0, 0, 0, 1);                // R9 header, R5 V flag
        line(52, 12, 0, 0, 0, 0, 0, 0);                // R6 misplaced
        for (int i = 0; i < 3; i++) line(52, 16, 0, 1, 0, 0, 0, 0); // R2 near prefixes
        for (int i = 0; i < 3; i++) line(52, 16, 1, 0, 1, 0, 0, 0); // R1 narrow
        line(52, 16, 1, 0, 0, 1, 0, 1);                // R3 detection off
        line(52, 16, 0, 0, 0, 0, 0, 0);
        // R10: raw mode passes near-extreme words unclipped
        step(10'h002, 0, 0, 1); step(10'h3FD, 0, 0, 1);
        line(52, 16, 1, 1, 0, 0, 1, 1);
        step(10'h001, 1, 0, 1);
        for (int i = 0; i < 40; i++) begin
            int len;
            len = ($urandom_range(0, 3) == 0) ? 50 : 48;
            line(len, 14, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0),
                 1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 1)));
        end
        data(3, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule